// File: doc/BRIEF.md
# Manual Reference Clock Selector

This controller decides which of four reference clock inputs feeds a downstream PLL. The choice comes from two external select pins and one pairing configuration pin. All three pins are treated as one word. The word passes through a synchronizer and a stability filter, and only then is it decoded.

With pairing off, each of the four codes names one input. With pairing on, inputs 1 and 3 travel together, as do inputs 2 and 4. In that mode only the two lower codes are meaningful and the two upper codes are refused. A high automatic-select control freezes the manual choice.

Each input has an alarm flag. The block raises a digital-hold request whenever any input in the current selection is alarmed.

Top module: `refsel_manual_ctrl`

## Requirements
- R1: After reset, `sel_onehot_o` is 0001 (input 1), and `pair_o`, `reserved_o` and `hold_req_o` are all low.
- R2: With the pairing pin low, an accepted code 00, 01, 10 or 11 sets bit 0, 1, 2 or 3 of `sel_onehot_o` respectively (inputs 1 to 4), and `pair_o` is low.
- R3: With the pairing pin high, accepted code 00 sets `sel_onehot_o` to 0001 and code 01 sets it to 0010. In both cases `pair_o` is high, meaning that input n+2 is selected together with input n.
- R4: With the pairing pin high, accepted codes 10 and 11 leave `sel_onehot_o` and `pair_o` unchanged and set `reserved_o`. `reserved_o` stays high until a valid code is accepted, which clears it.
- R5: A new pin word takes effect on clock edge SYNC_STAGES+STABLE_CYCLES-1, counting the first edge that samples it as edge 0. A word seen for fewer than STABLE_CYCLES consecutive synchronized samples has no effect.
- R6: A change of the pairing pin passes through the same synchronizer and stability filter, with the same latency and the same glitch rejection as the select pins.
- R7: While `auto_sel_i` is high, `sel_onehot_o`, `pair_o` and `reserved_o` do not change. On the first edge after `auto_sel_i` returns low, a pin word that is already stable is applied.
- R8: `hold_req_o` goes high one edge after the `alarm_i` bit of any selected input is high. In paired mode this includes the partner input. Alarms on inputs that are not selected have no effect.
- R9: `hold_req_o` falls one edge after the alarms of the selected inputs drop. It also falls one edge after a selection with no alarmed input takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_sel_i | input | 1 | Automatic-select control; manual selection acts only while low |
| pair_cfg_i | input | 1 | Pairing configuration pin (1 = inputs 1/3 and 2/4 paired) |
| sel_pins_i | input | 2 | Select code pins |
| alarm_i | input | 4 | Alarm flag per input, bit 0 = input 1 |
| sel_onehot_o | output | 4 | One-hot selected input (lower member in paired mode) |
| pair_o | output | 1 | High when the partner input n+2 is selected as well |
| reserved_o | output | 1 | Last accepted code was reserved |
| hold_req_o | output | 1 | Request for the PLL to enter digital hold |

## Verification
The bench builds the block with STABLE_CYCLES = 4 and SYNC_STAGES = 2. With these values the exact acceptance edge (edge 5) can be probed directly. A three-sample glitch, one short of the threshold, can be shown to be rejected. Every code, pairing change, reserved code and freeze is settled in under ten cycles, so all of them fit in one short run against the per-cycle model.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int SEL_W  = 2;
  localparam int NUM_IN = 1 << SEL_W;
  localparam int HALF   = NUM_IN / 2;

  typedef logic [SEL_W-1:0]  sel_code_t;
  typedef logic [NUM_IN-1:0] in_mask_t;

  typedef struct packed {
    logic      ok;
    logic      paired;
    sel_code_t idx;
  } dec_t;

  // Paired mode only accepts codes addressing the lower half of the inputs.
  function automatic dec_t decode_code(logic paired_cfg, sel_code_t code);
    dec_t d;
    d.paired = paired_cfg;
    d.idx    = code;
    d.ok     = !paired_cfg || (int'(code) < HALF);
    return d;
  endfunction

  // Inputs covered by a selection: the lower member, plus its partner when paired.
  function automatic in_mask_t member_mask(sel_code_t idx, logic paired);
    in_mask_t m;
    m = '0;
    m[idx] = 1'b1;
    if (paired) m[idx + sel_code_t'(HALF)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/refsel_filter.sv
module refsel_filter #(
  parameter int W      = 3,
  parameter int STABLE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_i,
  output logic         stable_o,
  output logic [W-1:0] val_o
);
  // STABLE must be at least 2.
  localparam int RUN_W   = $clog2(STABLE);
  localparam int RUN_MAX = STABLE - 1;

  logic [W-1:0]     cand_q;
  logic [RUN_W-1:0] run_q;
  logic             match_w;

  assign match_w  = (s_i == cand_q);
  assign stable_o = match_w && (run_q == RUN_W'(RUN_MAX));
  assign val_o    = s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      run_q  <= '0;
    end else if (match_w) begin
      if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + RUN_W'(1);
    end else begin
      cand_q <= s_i;
      run_q  <= RUN_W'(1);
    end
  end

  AST_STABLE_AFTER_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    stable_o |-> (s_i == $past(s_i))); // R5
endmodule

// File: rtl/refsel_select.sv
module refsel_select import refsel_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stable_i,
  input  logic [SEL_W:0] word_i,
  input  logic           auto_i,
  output sel_code_t      idx_o,
  output logic           pair_o,
  output logic           rsv_o
);
  dec_t      dec_w;
  logic      take_w;
  sel_code_t idx_q;
  logic      pair_q;
  logic      rsv_q;

  assign dec_w  = decode_code(word_i[SEL_W], word_i[SEL_W-1:0]);
  assign take_w = stable_i && !auto_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pair_q <= 1'b0;
      rsv_q  <= 1'b0;
    end else if (take_w) begin
      if (dec_w.ok) begin
        idx_q  <= dec_w.idx;
        pair_q <= dec_w.paired;
        rsv_q  <= 1'b0;
      end else begin
        rsv_q  <= 1'b1;
      end
    end
  end

  assign idx_o  = idx_q;
  assign pair_o = pair_q;
  assign rsv_o  = rsv_q;

  AST_RSV_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && !dec_w.ok) |=> (rsv_q && $stable(idx_q) && $stable(pair_q))); // R4
  AST_AUTO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_i |=> ($stable(idx_q) && $stable(pair_q) && $stable(rsv_q))); // R7
endmodule

// File: rtl/refsel_hold.sv
module refsel_hold import refsel_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_code_t         idx_i,
  input  logic              pair_i,
  input  logic [NUM_IN-1:0] alarm_i,
  output logic              hold_o
);
  in_mask_t watch_w;
  logic     hit_w;
  logic     hold_q;

  assign watch_w = member_mask(idx_i, pair_i);
  assign hit_w   = |(alarm_i & watch_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hit_w;
  end

  assign hold_o = hold_q;

  AST_HOLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> $past(|alarm_i)); // R8
  AST_QUIET_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_i == '0) |=> !hold_q); // R9
endmodule

// File: rtl/refsel_manual_ctrl.sv
module refsel_manual_ctrl import refsel_pkg::*; #(
  parameter int STABLE_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_sel_i,
  input  logic              pair_cfg_i,
  input  logic [SEL_W-1:0]  sel_pins_i,
  input  logic [NUM_IN-1:0] alarm_i,
  output logic [NUM_IN-1:0] sel_onehot_o,
  output logic              pair_o,
  output logic              reserved_o,
  output logic              hold_req_o
);
  localparam int WORD_W = SEL_W + 1;

  logic [WORD_W-1:0] pin_word_w;
  logic [WORD_W-1:0] sync_word_w;
  logic [WORD_W-1:0] filt_word_w;
  logic              stable_w;
  sel_code_t         idx_w;
  logic              pair_w;

  assign pin_word_w = {pair_cfg_i, sel_pins_i};

  refsel_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_word_w), .q_o(sync_word_w)
  );

  refsel_filter #(.W(WORD_W), .STABLE(STABLE_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .s_i(sync_word_w),
    .stable_o(stable_w), .val_o(filt_word_w)
  );

  refsel_select u_sel (
    .clk(clk), .rst_n(rst_n), .stable_i(stable_w), .word_i(filt_word_w),
    .auto_i(auto_sel_i), .idx_o(idx_w), .pair_o(pair_w), .rsv_o(reserved_o)
  );

  refsel_hold u_hold (
    .clk(clk), .rst_n(rst_n), .idx_i(idx_w), .pair_i(pair_w),
    .alarm_i(alarm_i), .hold_o(hold_req_o)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_onehot
    assign sel_onehot_o[g] = (idx_w == sel_code_t'(g));
  end

  assign pair_o = pair_w;

  AST_NO_CHANGE_UNFILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    !stable_w |=> ($stable(sel_onehot_o) && $stable(pair_o))); // R5
  AST_PAIR_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    pair_o |-> (sel_onehot_o[NUM_IN-1:HALF] == '0)); // R3
  AST_RSV_CLEARS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reserved_o) |-> $past(stable_w)); // R4
endmodule

// File: tb/sim_refsel_manual_ctrl.sv
module sim_refsel_manual_ctrl;
  localparam int STB = 4;
  localparam int SYN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_sel = 1'b0;
  logic       pair_cfg = 1'b0;
  logic [1:0] pins = 2'b00;
  logic [3:0] alarm = 4'b0000;
  logic [3:0] sel_onehot;
  logic       pair_o, rsv_o, hold_o;

  always #5 clk = ~clk;

  refsel_manual_ctrl #(.STABLE_CYCLES(STB), .SYNC_STAGES(SYN)) u0 (
    .clk(clk), .rst_n(rst_n), .auto_sel_i(auto_sel), .pair_cfg_i(pair_cfg),
    .sel_pins_i(pins), .alarm_i(alarm), .sel_onehot_o(sel_onehot),
    .pair_o(pair_o), .reserved_o(rsv_o), .hold_req_o(hold_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int         m_idx = 0;
  bit         m_pair = 0, m_rsv = 0, m_hold = 0;
  logic [2:0] pin_hist[$];
  logic [2:0] smp_hist[$];

  always @(posedge clk) begin
    logic [2:0] s;
    bit         same;
    bit         nh;
    if (!rst_n) begin
      m_idx = 0; m_pair = 0; m_rsv = 0; m_hold = 0;
      pin_hist.delete(); smp_hist.delete();
    end else begin
      pin_hist.push_front({pair_cfg, pins});
      if (pin_hist.size() > SYN + 1) void'(pin_hist.pop_back());
      s = (pin_hist.size() > SYN) ? pin_hist[SYN] : 3'b000;
      smp_hist.push_front(s);
      if (smp_hist.size() > STB) void'(smp_hist.pop_back());
      same = (smp_hist.size() == STB);
      foreach (smp_hist[k]) if (smp_hist[k] != s) same = 0;
      nh = alarm[m_idx] || (m_pair && alarm[m_idx + 2]);
      if (same && !auto_sel) begin
        if (s[2] && s[1]) m_rsv = 1;
        else begin m_idx = int'(s[1:0]); m_pair = s[2]; m_rsv = 0; end
      end
      m_hold = nh;
    end
  end

  task automatic check(string req, string what, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b (onehot,pair,rsv,hold)", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] oh;
    oh = 4'b0001 << m_idx;
    check(cur_req, "model", {sel_onehot, pair_o, rsv_o, hold_o}, {oh, m_pair, m_rsv, m_hold});
  end

  task automatic expect_out(string req, logic [3:0] oh, logic p, logic r, logic h);
    check(req, "directed", {sel_onehot, pair_o, rsv_o, hold_o}, {oh, p, r, h});
  endtask

  task automatic drive(logic cfg, logic [1:0] code);
    @(negedge clk);
    pair_cfg = cfg;
    pins = code;
  endtask

  task automatic settle();
    repeat (SYN + STB + 3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R5 watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1", 4'b0001, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 4'b0001, 0, 0, 0);

    cur_req = "R2";
    for (int c = 0; c < 4; c++) begin
      drive(0, 2'(c));
      settle();
      expect_out("R2", 4'b0001 << c, 0, 0, 0);
    end

    cur_req = "R5";
    drive(0, 2'b01);
    repeat (SYN + STB - 1) @(negedge clk);
    expect_out("R5", 4'b1000, 0, 0, 0);
    @(negedge clk);
    expect_out("R5", 4'b0010, 0, 0, 0);
    drive(0, 2'b10);
    repeat (STB - 2) @(negedge clk);
    drive(0, 2'b01);
    settle();
    expect_out("R5", 4'b0010, 0, 0, 0);

    cur_req = "R3";
    drive(1, 2'b00);
    settle();
    expect_out("R3", 4'b0001, 1, 0, 0);
    drive(1, 2'b01);
    settle();
    expect_out("R3", 4'b0010, 1, 0, 0);

    cur_req = "R4";
    drive(1, 2'b10);
    settle();
    expect_out("R4", 4'b0010, 1, 1, 0);
    drive(1, 2'b11);
    settle();
    expect_out("R4", 4'b0010, 1, 1, 0);
    drive(1, 2'b00);
    settle();
    expect_out("R4", 4'b0001, 1, 0, 0);

    cur_req = "R6";
    drive(0, 2'b00);
    drive(1, 2'b00);
    settle();
    expect_out("R6", 4'b0001, 1, 0, 0);
    drive(0, 2'b00);
    repeat (SYN + STB - 1) @(negedge clk);
    expect_out("R6", 4'b0001, 1, 0, 0);
    @(negedge clk);
    expect_out("R6", 4'b0001, 0, 0, 0);

    cur_req = "R7";
    drive(0, 2'b11);
    auto_sel = 1'b1;
    settle();
    settle();
    expect_out("R7", 4'b0001, 0, 0, 0);
    auto_sel = 1'b0;
    @(negedge clk);
    expect_out("R7", 4'b1000, 0, 0, 0);

    cur_req = "R8";
    alarm = 4'b0100;
    @(negedge clk);
    expect_out("R8", 4'b1000, 0, 0, 0);
    alarm = 4'b1000;
    @(negedge clk);
    expect_out("R8", 4'b1000, 0, 0, 1);
    cur_req = "R9";
    alarm = 4'b0000;
    @(negedge clk);
    expect_out("R9", 4'b1000, 0, 0, 0);
    alarm = 4'b1000;
    @(negedge clk);
    expect_out("R9", 4'b1000, 0, 0, 1);
    drive(0, 2'b00);
    settle();
    expect_out("R9", 4'b0001, 0, 0, 0);

    cur_req = "R8";
    drive(1, 2'b00);
    settle();
    expect_out("R8", 4'b0001, 1, 0, 0);
    alarm = 4'b0100;
    @(negedge clk);
    expect_out("R8", 4'b0001, 1, 0, 1);
    alarm = 4'b0000;
    @(negedge clk);
    expect_out("R9", 4'b0001, 1, 0, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule